// File: doc/BRIEF.md
# Reserved Mode Code Response Controller

This block sits in the message-handling path of a MIL-STD-1553 remote terminal. It handles received mode code commands whose 5-bit code is 22 through 31. Those codes have no defined action of their own. The host loads a 10-bit table with one bit per reserved code. A set bit makes the terminal reject the command as illegal. A clear bit makes the terminal answer it in form: it sources or sinks one data word through the buffer that the host assigned.

A decoder upstream pulses `cmd_stb` once for each received command word, together with the word's decoded fields. The controller samples those fields and the table in that cycle. It then works through a short sequence of states, waiting for the data word if the command is a legal receive. It issues its results as single-cycle strobes in two steps:
- a response step, which carries the status word actions and the buffer access;
- a write-back step, which carries the descriptor control word update, the message information word update and the interrupt requests.

Top module: `rsvd_mc_ctrl`

## Requirements
- R1: An invalid command word (`cmd_ok`=0) or a code below 22 produces no strobe of any kind. After reset, every output is 0.
- R2: A reserved code whose table bit is 1 is rejected, whatever its T/R bit.
  - Response step, two cycles after `cmd_stb`: `me_set` and `stat_tx`, with `data_tx` held low.
  - Write-back step, the next cycle: descriptor with `desc_dbac`=1, `desc_bcast`=0 and `desc_dpb_tgl`=1; info word with `info_ilcmd` and `info_merr` set; `irq_ilcmd` raised.
- R3: A legal transmit command (bit 0, T/R=1) has a response step two cycles after `cmd_stb` carrying `me_clr`, `stat_tx`, `data_tx` and `buf_rd`. Its write-back sets `desc_dbac`, clears `desc_bcast`, clears `info_merr`, `info_ilcmd` and `info_wcterr`, and raises `irq_iwa`.
- R4: A legal, non-broadcast receive command (bit 0, T/R=0) waits for `data_stb`. The response step falls in the cycle after the edge that samples `data_stb` and carries `me_clr`, `buf_wr` and `stat_tx`. Its write-back clears `desc_dbac` and raises `irq_iwa`.
- R5: A broadcast receive that gets its data word raises `bcr_set` and keeps `stat_tx` low. Its write-back sets `desc_bcast` and raises both `irq_iwa` and `irq_ibr`.
- R6: If no `data_stb` is sampled on any of the first GAP_CYC edges in the waiting state, the data word is declared missing (default GAP_CYC is 4). A data word sampled on the GAP_CYC-th edge is still accepted. A missing data word gives:
  - a response step with `me_set`, no status transmit, and `bcr_set` when the command was broadcast;
  - a write-back with `desc_dbac`=1, `desc_bcast` copied from the broadcast flag, and `info_merr` and `info_wcterr` set;
  - `irq_merr` and `irq_iwa` raised, plus `irq_ibr` when the command was broadcast.
- R7: Every handled outcome has a write-back cycle with `desc_we`, `desc_dpb_tgl` and `info_we` all set.
- R8: `info_busid` in the write-back cycle carries the value `cmd_bus` had in the `cmd_stb` cycle (0 = bus A, 1 = bus B).
- R9: The table bit used is `illeg_tbl[code-22]`, sampled in the `cmd_stb` cycle. Later changes to the table do not affect a command already in progress.
- R10: `buf_desc4` is high together with `buf_rd` or `buf_wr` exactly when `simple_mc` was high in the `cmd_stb` cycle. It selects the fourth descriptor word in place of the index or ping-pong buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command word received (one cycle) |
| cmd_ok | input | 1 | Command word passed validity checks |
| cmd_tr | input | 1 | T/R bit (1 = terminal transmits) |
| cmd_code | input | 5 | Mode code field |
| cmd_bcast | input | 1 | Command was broadcast |
| cmd_bus | input | 1 | Bus the command arrived on |
| illeg_tbl | input | 10 | Host table, one bit per reserved code |
| simple_mc | input | 1 | Use the fourth descriptor word as the data location |
| data_stb | input | 1 | Contiguous valid data word received |
| me_set | output | 1 | Set Message Error status bit |
| me_clr | output | 1 | Clear Message Error status bit |
| bcr_set | output | 1 | Set Broadcast Command Received status bit |
| stat_tx | output | 1 | Transmit the status word |
| data_tx | output | 1 | Transmit one data word after status |
| buf_rd | output | 1 | Read the data word from the buffer |
| buf_wr | output | 1 | Store the received data word |
| buf_desc4 | output | 1 | Buffer access targets the fourth descriptor word |
| desc_we | output | 1 | Descriptor control word write |
| desc_dbac | output | 1 | Descriptor "data block accessed" bit value |
| desc_bcast | output | 1 | Descriptor broadcast bit value |
| desc_dpb_tgl | output | 1 | Toggle the descriptor ping-pong select bit |
| info_we | output | 1 | Message info word write (unlisted bits written 0) |
| info_ilcmd | output | 1 | Info word illegal-command bit |
| info_merr | output | 1 | Info word message-error bit |
| info_wcterr | output | 1 | Info word word-count-error bit |
| info_busid | output | 1 | Info word bus identifier bit |
| irq_ilcmd | output | 1 | Illegal command interrupt pulse |
| irq_iwa | output | 1 | Index/word-accessed interrupt pulse |
| irq_ibr | output | 1 | Broadcast received interrupt pulse |
| irq_merr | output | 1 | Message error interrupt pulse |

## Verification
On every cycle, the embedded properties check these ordering rules:
- a response with a Message Error action is followed by a write-back;
- a sampled data word leads to a buffer store;
- an expired gap timer leads to a Message Error with no status transmit;
- a broadcast receive never transmits status;
- an illegal-command interrupt always follows a rejection that sent no data word.

Only the bench's scenarios can show the exact cycle at which each strobe appears and the full field pattern of each outcome. Those scenarios also cover the timeout boundary (data on the last allowed edge against no data at all), the handling of invalid and non-reserved codes, and the sampling of the table and the bus flag at command time.

// File: rtl/rsvd_mc_ctrl.sv
module rsvd_mc_ctrl #(
  parameter int GAP_CYC = 4,
  parameter logic [4:0] FIRST_RSVD = 5'd22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_stb,
  input  logic cmd_ok,
  input  logic cmd_tr,
  input  logic [4:0] cmd_code,
  input  logic cmd_bcast,
  input  logic cmd_bus,
  input  logic [31-FIRST_RSVD:0] illeg_tbl,
  input  logic simple_mc,
  input  logic data_stb,
  output logic me_set,
  output logic me_clr,
  output logic bcr_set,
  output logic stat_tx,
  output logic data_tx,
  output logic buf_rd,
  output logic buf_wr,
  output logic buf_desc4,
  output logic desc_we,
  output logic desc_dbac,
  output logic desc_bcast,
  output logic desc_dpb_tgl,
  output logic info_we,
  output logic info_ilcmd,
  output logic info_merr,
  output logic info_wcterr,
  output logic info_busid,
  output logic irq_ilcmd,
  output logic irq_iwa,
  output logic irq_ibr,
  output logic irq_merr
);
  localparam int CW = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {IDLE, EVAL, WAIT_DATA, RESPOND, WRITEBACK} st_t;
  typedef enum logic [1:0] {OC_ILL, OC_TX, OC_RX, OC_MISS} oc_t;

  st_t state;
  oc_t oc;
  logic [CW-1:0] cnt;
  logic ok_q, tr_q, bc_q, bus_q, ill_q, smc_q;
  logic [4:0] idx;

  assign idx = cmd_code - FIRST_RSVD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      oc    <= OC_ILL;
      cnt   <= '0;
      {ok_q, tr_q, bc_q, bus_q, ill_q, smc_q} <= '0;
    end else begin
      case (state)
        IDLE: if (cmd_stb) begin
          ok_q  <= cmd_ok && (cmd_code >= FIRST_RSVD);
          ill_q <= (cmd_code >= FIRST_RSVD) && illeg_tbl[idx];
          tr_q  <= cmd_tr;
          bc_q  <= cmd_bcast;
          bus_q <= cmd_bus;
          smc_q <= simple_mc;
          state <= EVAL;
        end
        EVAL: begin
          cnt <= '0;
          if (!ok_q)      state <= IDLE;
          else if (ill_q) begin oc <= OC_ILL; state <= RESPOND; end
          else if (tr_q)  begin oc <= OC_TX;  state <= RESPOND; end
          else            state <= WAIT_DATA;
        end
        WAIT_DATA: begin
          if (data_stb) begin
            oc <= OC_RX; state <= RESPOND;
          end else if (cnt == CW'(GAP_CYC - 1)) begin
            oc <= OC_MISS; state <= RESPOND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RESPOND:   state <= WRITEBACK;
        default:   state <= IDLE;
      endcase
    end
  end

  logic rs, wb, o_ill, o_tx, o_rx, o_miss;
  assign rs     = state == RESPOND;
  assign wb     = state == WRITEBACK;
  assign o_ill  = oc == OC_ILL;
  assign o_tx   = oc == OC_TX;
  assign o_rx   = oc == OC_RX;
  assign o_miss = oc == OC_MISS;

  assign me_set  = rs & (o_ill | o_miss);
  assign me_clr  = rs & (o_tx | o_rx);
  assign bcr_set = rs & bc_q & (o_rx | o_miss);
  assign stat_tx = rs & (o_ill | o_tx | (o_rx & ~bc_q));
  assign data_tx = rs & o_tx;
  assign buf_rd  = rs & o_tx;
  assign buf_wr  = rs & o_rx;
  assign buf_desc4 = smc_q & rs & (o_tx | o_rx);

  assign desc_we      = wb;
  assign desc_dbac    = wb & ~o_rx;
  assign desc_bcast   = wb & bc_q & (o_rx | o_miss);
  assign desc_dpb_tgl = wb;
  assign info_we      = wb;
  assign info_ilcmd   = wb & o_ill;
  assign info_merr    = wb & (o_ill | o_miss);
  assign info_wcterr  = wb & o_miss;
  assign info_busid   = wb & bus_q;
  assign irq_ilcmd    = wb & o_ill;
  assign irq_iwa      = wb & ~o_ill;
  assign irq_ibr      = wb & bc_q & (o_rx | o_miss);
  assign irq_merr     = wb & o_miss;

  a_r7_wb_after_me: assert property (@(posedge clk) disable iff (!rst_n)
    (me_set || me_clr) |=> (desc_we && info_we && desc_dpb_tgl));
  a_r4_data_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT_DATA && data_stb) |=> (buf_wr && me_clr));
  a_r6_gap_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT_DATA && !data_stb && cnt == CW'(GAP_CYC - 1)) |=> (me_set && !stat_tx));
  a_r5_bc_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bcr_set |-> !stat_tx);
  a_r2_ilcmd_origin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ilcmd |-> ($past(me_set) && !$past(data_tx) && $past(stat_tx)));
endmodule

// File: tb/rsvd_mc_ctrl_tb.sv
module rsvd_mc_ctrl_tb_top;
  localparam int GAP = 4;
  logic clk = 0, rst_n = 0;
  logic cmd_stb = 0, cmd_ok = 0, cmd_tr = 0, cmd_bcast = 0, cmd_bus = 0;
  logic [4:0] cmd_code = 0;
  logic [9:0] illeg_tbl = 0;
  logic simple_mc = 0, data_stb = 0;
  logic me_set, me_clr, bcr_set, stat_tx, data_tx, buf_rd, buf_wr, buf_desc4;
  logic desc_we, desc_dbac, desc_bcast, desc_dpb_tgl;
  logic info_we, info_ilcmd, info_merr, info_wcterr, info_busid;
  logic irq_ilcmd, irq_iwa, irq_ibr, irq_merr;

  always #2 clk = ~clk;

  rsvd_mc_ctrl #(.GAP_CYC(GAP)) dut_i (.*);

  int vectors = 0, miscompares = 0;
  logic [20:0] exp_v = '0;
  string tag = "R1";
  bit done = 0;

  wire [20:0] obs = {me_set, me_clr, bcr_set, stat_tx, data_tx, buf_rd, buf_wr, buf_desc4,
                     desc_we, desc_dbac, desc_bcast, desc_dpb_tgl,
                     info_we, info_ilcmd, info_merr, info_wcterr, info_busid,
                     irq_ilcmd, irq_iwa, irq_ibr, irq_merr};

  always @(posedge clk) begin
    #1;
    if (!done) begin
      vectors++;
      if (obs !== exp_v) begin
        miscompares++;
        $display("FAIL %s got %b expected %b", tag, obs, exp_v);
      end
    end
  end

  // outcome kinds: 0 illegal, 1 transmit, 2 receive, 3 missing data
  function automatic logic [20:0] resp_v(int k, bit bc, bit smc);
    logic [7:0] r;
    r = '0;
    r[7] = (k == 0 || k == 3);
    r[6] = (k == 1 || k == 2);
    r[5] = bc && (k == 2 || k == 3);
    r[4] = (k == 0 || k == 1 || (k == 2 && !bc));
    r[3] = (k == 1);
    r[2] = (k == 1);
    r[1] = (k == 2);
    r[0] = smc && (k == 1 || k == 2);
    return {r, 13'b0};
  endfunction

  function automatic logic [20:0] wb_v(int k, bit bc, bit bus);
    logic [12:0] w;
    w[12] = 1;
    w[11] = (k != 2);
    w[10] = bc && (k == 2 || k == 3);
    w[9]  = 1;
    w[8]  = 1;
    w[7]  = (k == 0);
    w[6]  = (k == 0 || k == 3);
    w[5]  = (k == 3);
    w[4]  = bus;
    w[3]  = (k == 0);
    w[2]  = (k != 0);
    w[1]  = bc && (k == 2 || k == 3);
    w[0]  = (k == 3);
    return {8'b0, w};
  endfunction

  task automatic step(bit cs, bit ds, logic [20:0] e);
    @(negedge clk);
    cmd_stb = cs;
    data_stb = ds;
    exp_v = e;
  endtask

  // data_at: wait-state edge index carrying data_stb, -1 for none
  task automatic mc(string t, bit ok, logic [4:0] code, bit tr, bit bc, bit bus,
                    bit smc, int data_at, logic [9:0] tbl_after);
    int k;
    @(negedge clk);
    tag = t;
    cmd_stb = 1; cmd_ok = ok; cmd_code = code; cmd_tr = tr;
    cmd_bcast = bc; cmd_bus = bus; simple_mc = smc; data_stb = 0;
    exp_v = '0;
    step(0, 0, '0);
    illeg_tbl = tbl_after;
    cmd_bus = ~bus; simple_mc = ~smc; cmd_bcast = ~bc;
    if (!ok || code < 5'd22) begin
      step(0, 0, '0); step(0, 0, '0); step(0, 0, '0);
      return;
    end
    // exp_v for the current cycle was set above; decide outcome from sampled table
    k = -1;
    if (ill_at_cmd) k = 0;
    else if (tr) k = 1;
    if (k >= 0) begin
      exp_v = resp_v(k, bc, smc);
    end else begin
      for (int i = 0; i < GAP; i++) begin
        if (i == data_at) begin k = 2; step(0, 1, resp_v(2, bc, smc)); break; end
        if (i == GAP - 1) begin k = 3; step(0, 0, resp_v(3, bc, smc)); break; end
        step(0, 0, '0);
      end
    end
    step(0, 0, wb_v(k, bc, bus));
    step(0, 0, '0);
    step(0, 0, '0);
  endtask

  bit ill_at_cmd;

  task automatic run(string t, bit ok, logic [4:0] code, bit tr, bit bc, bit bus,
                     bit smc, int data_at, logic [9:0] tbl, logic [9:0] tbl_after);
    illeg_tbl = tbl;
    ill_at_cmd = (code >= 5'd22) ? tbl[code - 5'd22] : 1'b0;
    mc(t, ok, code, tr, bc, bus, smc, data_at, tbl_after);
  endtask

  initial begin
    tag = "R1 reset";
    repeat (3) step(0, 0, '0);
    @(negedge clk); rst_n = 1;
    repeat (2) step(0, 0, '0);

    run("R1 invalid", 0, 5'd31, 1, 0, 0, 0, -1, 10'h3FF, 10'h3FF);
    run("R1 code21",  1, 5'd21, 1, 0, 0, 0, -1, 10'h3FF, 10'h3FF);
    run("R1 code0",   1, 5'd0,  0, 1, 1, 0, -1, 10'h000, 10'h000);

    run("R2 ill tx code22", 1, 5'd22, 1, 0, 1, 0, -1, 10'h001, 10'h001);
    run("R2 ill rx code31", 1, 5'd31, 0, 0, 0, 0, -1, 10'h200, 10'h200);
    run("R2 ill bc", 1, 5'd28, 0, 1, 1, 1, -1, 10'h040, 10'h040);

    run("R3 tx R8 bus1", 1, 5'd25, 1, 0, 1, 0, -1, 10'h3F7, 10'h3F7);
    run("R3 tx R10 desc4", 1, 5'd30, 1, 0, 0, 1, -1, 10'h000, 10'h000);

    run("R4 rx first edge", 1, 5'd23, 0, 0, 0, 0, 0, 10'h000, 10'h000);
    run("R4 rx R10 desc4", 1, 5'd29, 0, 0, 1, 1, 2, 10'h000, 10'h000);
    run("R5 bc rx", 1, 5'd24, 0, 1, 0, 0, 1, 10'h000, 10'h000);

    run("R6 miss", 1, 5'd26, 0, 0, 1, 0, -1, 10'h000, 10'h000);
    run("R6 miss bc", 1, 5'd27, 0, 1, 0, 0, -1, 10'h000, 10'h000);
    run("R6 last edge", 1, 5'd31, 0, 0, 0, 0, GAP - 1, 10'h000, 10'h000);

    run("R9 tbl set then cleared", 1, 5'd27, 1, 0, 0, 0, -1, 10'h020, 10'h000);
    run("R9 tbl clear then set", 1, 5'd27, 1, 0, 0, 0, -1, 10'h000, 10'h3FF);
    run("R7 R8 bus0 ill", 1, 5'd24, 1, 0, 0, 0, -1, 10'h004, 10'h004);

    step(0, 0, '0);
    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired tag %s got %0d expected 0", tag, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule